// File: doc/BRIEF.md
# Epoch Signature Race Checker

This block decides whether two epochs, possibly from different threads, may have touched a common memory location in a way that forms a data race. Each epoch is described by two Bloom-filter signatures: one that summarises its loads and one that summarises its stores. Every signature is split into a fixed number of equal bins. An address sets one bit in each bin.

A pair of signatures is taken to share an address only when every bin has at least one bit position set in both. Three pairings are tested:
- store against store;
- store of epoch A against load of epoch B;
- load of epoch A against store of epoch B.

Load against load is never a race. A positive answer may be caused by aliasing. It is reported as it is, with no attempt to filter it.

A one-cycle start strobe latches the comparison. On the next cycle a done pulse appears, carrying a race flag and a per-pairing hit vector. The signature width is a parameter (512, 1024 or 2048 bits by default use). The bin count defaults to eight.

Top module: `sig_race_chk`

## Requirements
- R1: After rst_ni is asserted low, done_o, race_o and pair_o are all zero.
- R2: done_o is high exactly in the cycle after a cycle in which start_i was sampled high, and low otherwise.
- R3: A bin matches when the two operands have at least one common set bit inside that bin's BIN_W-bit slice. Bin k occupies bits [k*BIN_W +: BIN_W].
- R4: A pairing hits only when all N_BINS bins match. A single bin without a common bit clears the hit.
- R5: The pair_o encoding is as follows:
  - bit 0 = A store vs B store (a_wr_sig_i, b_wr_sig_i);
  - bit 1 = A store vs B load (a_wr_sig_i, b_rd_sig_i);
  - bit 2 = A load vs B store (a_rd_sig_i, b_wr_sig_i).
- R6: Overlap between a_rd_sig_i and b_rd_sig_i alone never sets race_o or any pair_o bit.
- R7: With done_o high, race_o equals the OR of the three pair_o bits.
- R8: An all-zero signature operand never produces a hit in any pairing that uses it.
- R9: While done_o is low, race_o and pair_o are zero.
- R10: Starts on consecutive cycles each give their own result on the following cycle, with no mixing between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Latch a comparison of the present operands |
| a_rd_sig_i | input | SIG_W | Epoch A load signature |
| a_wr_sig_i | input | SIG_W | Epoch A store signature |
| b_rd_sig_i | input | SIG_W | Epoch B load signature |
| b_wr_sig_i | input | SIG_W | Epoch B store signature |
| done_o | output | 1 | Result valid, one cycle after start_i |
| race_o | output | 1 | Potential race found |
| pair_o | output | 3 | Per-pairing hits, encoded as in R5 |

## Verification
Two things can coincide in one cycle:
- the done pulse of one comparison and the start of the next;
- hits in several pairings at once.

The bench issues starts back to back, with no gap, from a sixteen-bit, eight-bin configuration. Every result is compared against a bin-wise overlap computed arithmetically for the operands that belong to that particular start. Random operands often make two or three pairings hit together. In those cycles the bench checks that the exact pair vector and the race flag agree with the expected value for each pairing.

// File: rtl/sig_race_pkg.sv
package sig_race_pkg;
  localparam int N_PAIRS = 3;
  localparam int PAIR_WW = 0;
  localparam int PAIR_WR = 1;
  localparam int PAIR_RW = 2;
  typedef logic [N_PAIRS-1:0] pair_vec_t;
endpackage

// File: rtl/sig_bin_hit.sv
module sig_bin_hit #(
  parameter int BIN_W = 256
) (
  input  logic [BIN_W-1:0] x_i,
  input  logic [BIN_W-1:0] y_i,
  output logic             hit_o
);
  assign hit_o = |(x_i & y_i);
endmodule

// File: rtl/sig_pair_match.sv
module sig_pair_match #(
  parameter int SIG_W  = 2048,
  parameter int N_BINS = 8
) (
  input  logic [SIG_W-1:0] x_i,
  input  logic [SIG_W-1:0] y_i,
  output logic             match_o
);
  localparam int BIN_W = SIG_W / N_BINS;

  logic [N_BINS-1:0] bin_hit;

  for (genvar k = 0; k < N_BINS; k++) begin : g_bin
    sig_bin_hit #(.BIN_W(BIN_W)) u_bin (
      .x_i  (x_i[k*BIN_W +: BIN_W]),
      .y_i  (y_i[k*BIN_W +: BIN_W]),
      .hit_o(bin_hit[k])
    );
  end

  // every bin must intersect (partitioned Bloom membership)
  assign match_o = &bin_hit;
endmodule

// File: rtl/sig_race_chk.sv
module sig_race_chk
  import sig_race_pkg::*;
#(
  parameter int SIG_W  = 2048,
  parameter int N_BINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SIG_W-1:0] a_rd_sig_i,
  input  logic [SIG_W-1:0] a_wr_sig_i,
  input  logic [SIG_W-1:0] b_rd_sig_i,
  input  logic [SIG_W-1:0] b_wr_sig_i,
  output logic             done_o,
  output logic             race_o,
  output logic [2:0]       pair_o
);
  pair_vec_t hit_d, pair_q;
  logic      done_q, race_q;

  // operand selection per pairing; read-read deliberately absent
  logic [SIG_W-1:0] lhs [N_PAIRS];
  logic [SIG_W-1:0] rhs [N_PAIRS];

  assign lhs[PAIR_WW] = a_wr_sig_i;
  assign rhs[PAIR_WW] = b_wr_sig_i;
  assign lhs[PAIR_WR] = a_wr_sig_i;
  assign rhs[PAIR_WR] = b_rd_sig_i;
  assign lhs[PAIR_RW] = a_rd_sig_i;
  assign rhs[PAIR_RW] = b_wr_sig_i;

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    sig_pair_match #(.SIG_W(SIG_W), .N_BINS(N_BINS)) u_match (
      .x_i    (lhs[p]),
      .y_i    (rhs[p]),
      .match_o(hit_d[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      race_q <= 1'b0;
      pair_q <= '0;
    end else begin
      done_q <= start_i;
      race_q <= start_i & (|hit_d);
      pair_q <= start_i ? hit_d : '0;
    end
  end

  assign done_o = done_q;
  assign race_o = race_q;
  assign pair_o = pair_q;

  // R2
  done_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  // R2
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  // R9
  quiet_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!race_o && pair_o == '0));
  // R7
  race_matches_pairs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (race_o == (pair_o != '0)));
  // R8
  zero_a_no_race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && a_rd_sig_i == '0 && a_wr_sig_i == '0) |=> !race_o);
  // R6
  rd_rd_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && a_wr_sig_i == '0 && b_wr_sig_i == '0) |=> pair_o == '0);
endmodule

// File: tb/tb_sig_race_chk.sv
module tb_sig_race_chk;
  localparam int SW = 16;
  localparam int NB = 8;
  localparam int BW = SW / NB;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [SW-1:0] a_rd_sig_i = '0, a_wr_sig_i = '0, b_rd_sig_i = '0, b_wr_sig_i = '0;
  logic          done_o, race_o;
  logic [2:0]    pair_o;

  int n_chk = 0, n_fail = 0;
  bit pend = 0;
  logic [2:0] exp_pair;
  string exp_req;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk_i = ~clk_i;

  sig_race_chk #(.SIG_W(SW), .N_BINS(NB)) dut (.*);

  function automatic bit ovl(logic [SW-1:0] x, logic [SW-1:0] y);
    for (int b = 0; b < NB; b++)
      if ((((x >> (BW*b)) & (y >> (BW*b))) & ((1 << BW) - 1)) == 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string req, logic [4:0] got, logic [4:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s {done,race,pair} got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic settle_prev();
    if (pend) check(exp_req, {done_o, race_o, pair_o}, {1'b1, |exp_pair, exp_pair});
  endtask

  task automatic issue(string req, logic [SW-1:0] ar, logic [SW-1:0] aw,
                       logic [SW-1:0] br, logic [SW-1:0] bw);
    @(negedge clk_i);
    settle_prev();
    a_rd_sig_i = ar; a_wr_sig_i = aw; b_rd_sig_i = br; b_wr_sig_i = bw;
    start_i = 1'b1;
    exp_pair = {ovl(ar, bw), ovl(aw, br), ovl(aw, bw)};
    exp_req = req;
    pend = 1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    settle_prev();
    pend = 0;
    start_i = 1'b0;
    @(negedge clk_i);
    check("R9/R2 idle", {done_o, race_o, pair_o}, 5'b0);
  endtask

  function automatic logic [15:0] nxt(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [SW-1:0] full, v;
    full = '1;
    #20;
    @(negedge clk_i);
    check("R1 reset", {done_o, race_o, pair_o}, 5'b0);
    rst_ni = 1'b1;
    idle();
    // R3 R4: sweep every bin with all value combos, other bins fully overlapping
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < (1 << BW); p++)
        for (int q = 0; q < (1 << BW); q++) begin
          logic [SW-1:0] x, y;
          x = full; y = full;
          x[b*BW +: BW] = BW'(p);
          y[b*BW +: BW] = BW'(q);
          issue("R3/R4 bin sweep", '0, x, '0, y);
        end
    idle();
    // R5: each pairing alone
    issue("R5 ww only", '0, full, '0, full);
    issue("R5 wr only", '0, full, full, '0);
    issue("R5 rw only", full, '0, '0, full);
    // R6: read-read overlap only
    issue("R6 rd-rd", full, '0, full, '0);
    // R8: zero operand
    issue("R8 zero a_wr", full, '0, full, full);
    issue("R8 zero b_wr", full, full, full, '0);
    idle();
    // R7 R10: random back-to-back
    for (int i = 0; i < 400; i++) begin
      logic [SW-1:0] r0, r1, r2, r3;
      lfsr = nxt(lfsr); r0 = lfsr | nxt(lfsr);
      lfsr = nxt(nxt(lfsr)); r1 = lfsr | {lfsr[7:0], lfsr[15:8]};
      lfsr = nxt(nxt(lfsr)); r2 = lfsr | ~nxt(lfsr);
      lfsr = nxt(nxt(lfsr)); r3 = lfsr | {lfsr[3:0], lfsr[15:4]};
      issue("R7/R10 random b2b", r0, r1, r2, r3);
    end
    idle();
    v = '0;
    issue("R8 all zero", v, v, v, v);
    idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule